// File: doc/BRIEF.md
# Caller-ID Detection Mode and Interrupt Controller

This block decides which detector of a caller-ID receiver is switched on, and it reports detector activity to a host microcontroller. It works from two inputs. The first is a power-down level that an analog front end has already quantised into three levels: low, one-third of supply, and high. The second is the telephone hook state. From these it enables one of three detectors: the ring / line-polarity-reversal detector, the alert-tone (CAS) detector, or the 1200-baud FSK demodulator. It also sequences tone detection into FSK reception. Strobes from the detectors drive a latched, active-low interrupt and a MODE status line. The MODE line goes low for a programmable time after an alert tone.

The host acknowledges the interrupt with a strobe. The host can also re-initialise the block by pulling the power-down input low for a short time, for example after a false tone response or after a complete FSK message. The pulse length is measured in clocks. A low inside a set window counts as a re-initialisation. A shorter low is a glitch and has no effect. A longer low is a genuine change to the low level.

Top module: `cid_mode_ctrl`

## Requirements
- R1: After reset the interrupt output is high and MODE is high. The power-down level is taken as high, so with on-hook only the ring enable is high.
- R2: Code `pd_code` 00 means low, 01 means one-third and 10 means high. Code 11 is also treated as high. A non-low code is reflected in the enables one clock after it is sampled. A change of `off_hook` also shows one clock after it is sampled.
- R3: With the low level and on-hook, only `fsk_en` is high.
- R4: With the low level and off-hook, or with the one-third level in either hook state, the block starts in the tone phase. In that phase only `cas_en` is high.
- R5: With the high level and on-hook, only `ring_en` is high. With the high level and off-hook, all three enables are low.
- R6: A CAS strobe taken while `cas_en` is high moves the block to the alert phase, where `cas_en` and `fsk_en` are both high. The first mark strobe then accepted moves it to the data phase, where only `fsk_en` is high.
- R7: A strobe from an enabled detector drives `irq_n` low one clock later. A strobe from a disabled detector changes neither `irq_n` nor MODE.
- R8: `irq_n` stays low until the host sends `irq_ack`. If an accepted event arrives in the same cycle as `irq_ack`, the interrupt stays asserted.
- R9: An accepted CAS strobe drives MODE low for exactly MODE_LOW_CLKS clocks. A further accepted CAS strobe restarts that time.
- R10: An accepted ring or mark strobe drives MODE high one clock later, even in the middle of the MODE-low time.
- R11: A low on `pd_code` that lasts N sampled clocks, with PULSE_MIN <= N <= PULSE_MAX, re-initialises the block. Two clocks after the code returns to non-low, `irq_n` and MODE are high and the block is back in the tone phase. While the low lasts, the enables keep their previous values.
- R12: A low shorter than PULSE_MIN clocks is ignored. The interrupt, the phase and the enables are unchanged.
- R13: A low that lasts longer than PULSE_MAX clocks is taken as the low level from its (PULSE_MAX+1)-th sampled clock on. When it ends, no re-initialisation occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_code | input | 2 | Quantised power-down level (00 low, 01 one-third, 10/11 high) |
| off_hook | input | 1 | Hook state, 1 = off-hook |
| ring_evt | input | 1 | Ring / polarity-reversal detected strobe |
| cas_evt | input | 1 | Alert tone detected strobe |
| mark_evt | input | 1 | FSK mark signal detected strobe |
| irq_ack | input | 1 | Host interrupt acknowledge strobe |
| ring_en | output | 1 | Enable for the ring / reversal detector |
| cas_en | output | 1 | Enable for the alert-tone detector |
| fsk_en | output | 1 | Enable for the FSK demodulator |
| irq_n | output | 1 | Active-low latched interrupt |
| mode_o | output | 1 | Status line, low while an alert-tone window runs |

## Verification
The bench builds the block with PULSE_MIN = 4, PULSE_MAX = 8 and MODE_LOW_CLKS = 20. With these values, both edges of the re-initialisation window can be reached in a handful of clocks: a 3-clock glitch, a 5-clock pulse, an exactly-8-clock pulse, and a 9-clock low that becomes a level change. The 20-clock MODE window is short enough to observe its last low cycle and first high cycle exactly. It is also long enough to restart it part-way through and to cut it short with a mark strobe.

// File: rtl/cid_mode_pkg.sv
package cid_mode_pkg;

  // Quantised power-down level after decoding
  typedef enum logic [1:0] {
    LVL_LOW   = 2'd0,
    LVL_THIRD = 2'd1,
    LVL_HIGH  = 2'd2
  } pd_lvl_e;

  // Detector category chosen from level and hook state
  typedef enum logic [1:0] {
    CAT_NONE     = 2'd0,
    CAT_FSK      = 2'd1,
    CAT_TONE_FSK = 2'd2,
    CAT_RING     = 2'd3
  } det_cat_e;

  // Progress inside the tone-then-FSK category
  typedef enum logic [1:0] {
    PH_TONE  = 2'd0,
    PH_ALERT = 2'd1,
    PH_DATA  = 2'd2
  } seq_phase_e;

  function automatic pd_lvl_e decode_pd(input logic [1:0] code);
    case (code)
      2'b00:   return LVL_LOW;
      2'b01:   return LVL_THIRD;
      default: return LVL_HIGH;
    endcase
  endfunction

  function automatic det_cat_e lookup_cat(input pd_lvl_e lvl, input logic hook);
    case (lvl)
      LVL_LOW:   return hook ? CAT_TONE_FSK : CAT_FSK;
      LVL_THIRD: return CAT_TONE_FSK;
      default:   return hook ? CAT_NONE : CAT_RING;
    endcase
  endfunction

  function automatic logic pulse_in_window(input int unsigned len,
                                           input int unsigned lo,
                                           input int unsigned hi);
    return (len >= lo) && (len <= hi);
  endfunction

endpackage

// File: rtl/cid_pd_filter.sv
module cid_pd_filter
  import cid_mode_pkg::*;
#(
  parameter int unsigned PULSE_MIN = 18,
  parameter int unsigned PULSE_MAX = 72
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pd_code,
  output pd_lvl_e    eff_lvl,
  output logic       reinit_pulse
);

  localparam int unsigned SAT_VAL = PULSE_MAX + 1;
  localparam int unsigned CW      = $clog2(SAT_VAL + 1);

  logic [CW-1:0] low_cnt;
  logic          pd_low;
  logic          at_limit;

  assign pd_low   = (decode_pd(pd_code) == LVL_LOW);
  assign at_limit = (low_cnt == CW'(PULSE_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt      <= '0;
      eff_lvl      <= LVL_HIGH;
      reinit_pulse <= 1'b0;
    end else begin
      reinit_pulse <= 1'b0;
      if (pd_low) begin
        if (low_cnt != CW'(SAT_VAL))
          low_cnt <= low_cnt + 1'b1;
        if (at_limit)
          eff_lvl <= LVL_LOW;
      end else begin
        low_cnt      <= '0;
        eff_lvl      <= decode_pd(pd_code);
        reinit_pulse <= pulse_in_window(int'(low_cnt), PULSE_MIN, PULSE_MAX);
      end
    end
  end

endmodule

// File: rtl/cid_det_sequencer.sv
module cid_det_sequencer
  import cid_mode_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pd_lvl_e eff_lvl,
  input  logic    off_hook,
  input  logic    reinit_pulse,
  input  logic    ring_evt,
  input  logic    cas_evt,
  input  logic    mark_evt,
  output logic    ring_en,
  output logic    cas_en,
  output logic    fsk_en,
  output logic    ring_acc,
  output logic    cas_acc,
  output logic    mark_acc
);

  logic       hook_q;
  det_cat_e   cat;
  seq_phase_e phase;
  logic       tone_cat;

  assign cat      = lookup_cat(eff_lvl, hook_q);
  assign tone_cat = (cat == CAT_TONE_FSK);

  always_comb begin
    ring_en = (cat == CAT_RING);
    cas_en  = tone_cat && (phase != PH_DATA);
    fsk_en  = (cat == CAT_FSK) || (tone_cat && (phase != PH_TONE));
  end

  assign ring_acc = ring_evt & ring_en;
  assign cas_acc  = cas_evt  & cas_en;
  assign mark_acc = mark_evt & fsk_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hook_q <= 1'b0;
      phase  <= PH_TONE;
    end else begin
      hook_q <= off_hook;
      if (reinit_pulse || !tone_cat) begin
        phase <= PH_TONE;
      end else begin
        case (phase)
          PH_TONE:  if (cas_acc)  phase <= PH_ALERT;
          PH_ALERT: if (mark_acc) phase <= PH_DATA;
          PH_DATA:  phase <= PH_DATA;
          default:  phase <= PH_TONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/cid_status_gen.sv
module cid_status_gen #(
  parameter int unsigned MODE_LOW_CLKS = 35800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reinit_pulse,
  input  logic ring_acc,
  input  logic cas_acc,
  input  logic mark_acc,
  input  logic irq_ack,
  output logic irq_n,
  output logic mode_o
);

  localparam int unsigned TW = $clog2(MODE_LOW_CLKS + 1);

  logic          irq_q;
  logic          mode_low;
  logic [TW-1:0] tmr;
  logic          any_acc;

  assign any_acc = ring_acc | cas_acc | mark_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (reinit_pulse) begin
      irq_q <= 1'b0;
    end else if (any_acc) begin
      irq_q <= 1'b1;
    end else if (irq_ack) begin
      irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_low <= 1'b0;
      tmr      <= '0;
    end else if (reinit_pulse) begin
      mode_low <= 1'b0;
      tmr      <= '0;
    end else if (cas_acc) begin
      mode_low <= 1'b1;
      tmr      <= TW'(MODE_LOW_CLKS);
    end else if (ring_acc || mark_acc) begin
      mode_low <= 1'b0;
      tmr      <= '0;
    end else if (mode_low) begin
      if (tmr == TW'(1)) begin
        mode_low <= 1'b0;
        tmr      <= '0;
      end else begin
        tmr <= tmr - 1'b1;
      end
    end
  end

  assign irq_n  = ~irq_q;
  assign mode_o = ~mode_low;

endmodule

// File: rtl/cid_mode_ctrl.sv
module cid_mode_ctrl
  import cid_mode_pkg::*;
#(
  parameter int unsigned PULSE_MIN     = 18,
  parameter int unsigned PULSE_MAX     = 72,
  parameter int unsigned MODE_LOW_CLKS = 35800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pd_code,
  input  logic       off_hook,
  input  logic       ring_evt,
  input  logic       cas_evt,
  input  logic       mark_evt,
  input  logic       irq_ack,
  output logic       ring_en,
  output logic       cas_en,
  output logic       fsk_en,
  output logic       irq_n,
  output logic       mode_o
);

  // Named internal events, also observed by the bound checker
  pd_lvl_e eff_lvl;
  logic    reinit_pulse;
  logic    ring_acc;
  logic    cas_acc;
  logic    mark_acc;

  cid_pd_filter #(
    .PULSE_MIN (PULSE_MIN),
    .PULSE_MAX (PULSE_MAX)
  ) u_filter (
    .clk          (clk),
    .rst_n        (rst_n),
    .pd_code      (pd_code),
    .eff_lvl      (eff_lvl),
    .reinit_pulse (reinit_pulse)
  );

  cid_det_sequencer u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .eff_lvl      (eff_lvl),
    .off_hook     (off_hook),
    .reinit_pulse (reinit_pulse),
    .ring_evt     (ring_evt),
    .cas_evt      (cas_evt),
    .mark_evt     (mark_evt),
    .ring_en      (ring_en),
    .cas_en       (cas_en),
    .fsk_en       (fsk_en),
    .ring_acc     (ring_acc),
    .cas_acc      (cas_acc),
    .mark_acc     (mark_acc)
  );

  cid_status_gen #(
    .MODE_LOW_CLKS (MODE_LOW_CLKS)
  ) u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .reinit_pulse (reinit_pulse),
    .ring_acc     (ring_acc),
    .cas_acc      (cas_acc),
    .mark_acc     (mark_acc),
    .irq_ack      (irq_ack),
    .irq_n        (irq_n),
    .mode_o       (mode_o)
  );

endmodule

// File: rtl/cid_mode_ctrl_chk.sv
module cid_mode_ctrl_chk #(
  parameter int unsigned MODE_LOW_CLKS = 35800
) (
  input logic clk,
  input logic rst_n,
  input logic irq_ack,
  input logic ring_en,
  input logic cas_en,
  input logic fsk_en,
  input logic irq_n,
  input logic mode_o,
  input logic ring_acc,
  input logic cas_acc,
  input logic mark_acc,
  input logic reinit_pulse
);

  localparam int unsigned RW = $clog2(MODE_LOW_CLKS + 2);

  // Length of the current MODE-low run, restarted by each accepted tone
  logic [RW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      low_run <= '0;
    else if (mode_o || cas_acc)
      low_run <= '0;
    else if (low_run != RW'(MODE_LOW_CLKS + 1))
      low_run <= low_run + 1'b1;
  end

  assert_ring_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ring_en |-> (!cas_en && !fsk_en));

  assert_irq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ring_acc || cas_acc || mark_acc) && !reinit_pulse) |=> !irq_n);

  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !irq_ack && !reinit_pulse) |=> !irq_n);

  assert_mode_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_acc && !reinit_pulse) |=> !mode_o);

  assert_mode_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= RW'(MODE_LOW_CLKS));

  assert_mode_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((ring_acc || mark_acc) && !reinit_pulse) |=> mode_o);

  assert_reinit_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_pulse |=> (irq_n && mode_o));

endmodule

bind cid_mode_ctrl cid_mode_ctrl_chk #(
  .MODE_LOW_CLKS (MODE_LOW_CLKS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq_ack      (irq_ack),
  .ring_en      (ring_en),
  .cas_en       (cas_en),
  .fsk_en       (fsk_en),
  .irq_n        (irq_n),
  .mode_o       (mode_o),
  .ring_acc     (ring_acc),
  .cas_acc      (cas_acc),
  .mark_acc     (mark_acc),
  .reinit_pulse (reinit_pulse)
);

// File: tb/tb_cid_mode_ctrl.sv
module tb_cid_mode_ctrl;

  localparam int unsigned L = 20;
  localparam logic [4:0] M_ALL  = 5'b11111;
  localparam logic [4:0] M_EN   = 5'b11100;
  localparam logic [4:0] M_IRQ  = 5'b00010;
  localparam logic [4:0] M_MODE = 5'b00001;
  localparam logic [4:0] M_IM   = 5'b00011;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] pd_code;
  logic       off_hook, ring_evt, cas_evt, mark_evt, irq_ack;
  logic       ring_en, cas_en, fsk_en, irq_n, mode_o;

  always #4 clk = ~clk;

  cid_mode_ctrl #(
    .PULSE_MIN     (4),
    .PULSE_MAX     (8),
    .MODE_LOW_CLKS (L)
  ) dut (
    .clk (clk), .rst_n (rst_n), .pd_code (pd_code), .off_hook (off_hook),
    .ring_evt (ring_evt), .cas_evt (cas_evt), .mark_evt (mark_evt),
    .irq_ack (irq_ack), .ring_en (ring_en), .cas_en (cas_en),
    .fsk_en (fsk_en), .irq_n (irq_n), .mode_o (mode_o)
  );

  typedef struct {
    int         when;
    logic [4:0] mask;
    logic [4:0] val;
    string      req;
  } exp_item_t;

  exp_item_t sb[$];
  int  cyc = 0;
  int  n_checks = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  // Expected vector layout: {ring_en, cas_en, fsk_en, irq_n, mode_o}
  task automatic expect_at(input int off, input logic [4:0] mask,
                           input logic [4:0] val, input string req);
    exp_item_t it;
    it.when = cyc + off;
    it.mask = mask;
    it.val  = val;
    it.req  = req;
    sb.push_back(it);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: samples mid-cycle after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #2;
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].when == cyc) begin
          logic [4:0] obs;
          obs = {ring_en, cas_en, fsk_en, irq_n, mode_o};
          n_checks++;
          if ((obs & sb[i].mask) != (sb[i].val & sb[i].mask)) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %b expected %b (mask %b)",
                     sb[i].req, cyc, obs & sb[i].mask, sb[i].val & sb[i].mask,
                     sb[i].mask);
          end
          sb.delete(i);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pd_code = 2'b10; off_hook = 1'b0;
    ring_evt = 1'b0; cas_evt = 1'b0; mark_evt = 1'b0; irq_ack = 1'b0;
    tick(3);
    rst_n = 1'b1;
    expect_at(1, M_ALL, 5'b10011, "R1 reset state");
    tick(2);

    // R7 ring accepted, R8 hold and acknowledge
    ring_evt = 1'b1;
    expect_at(1, M_IM, 5'b00001, "R7 ring sets irq");
    tick(1); ring_evt = 1'b0;
    tick(3);
    expect_at(1, M_IRQ, 5'b00000, "R8 irq held");
    tick(1);
    irq_ack = 1'b1;
    expect_at(1, M_IRQ, 5'b00010, "R8 ack clears");
    tick(1); irq_ack = 1'b0;

    // R7 disabled tone detector ignored
    cas_evt = 1'b1;
    expect_at(1, M_IM, 5'b00011, "R7 disabled cas ignored");
    tick(1); cas_evt = 1'b0; tick(1);

    off_hook = 1'b1;
    expect_at(1, M_ALL, 5'b00011, "R5 high off-hook none");
    tick(2);
    pd_code = 2'b01;
    expect_at(1, M_ALL, 5'b01011, "R4 third off-hook tone");
    tick(2);
    off_hook = 1'b0;
    expect_at(1, M_ALL, 5'b01011, "R4 third on-hook tone");
    tick(2);
    pd_code = 2'b11;
    expect_at(1, M_ALL, 5'b10011, "R2 code 11 is high");
    tick(2);
    pd_code = 2'b01;
    expect_at(1, M_ALL, 5'b01011, "R2 code 01 is third");
    tick(2);
    mark_evt = 1'b1;
    expect_at(1, M_IM, 5'b00011, "R7 disabled mark ignored");
    tick(1); mark_evt = 1'b0; tick(1);

    // R6 alert phase, R9 window length
    cas_evt = 1'b1;
    expect_at(1, M_ALL, 5'b01100, "R6 alert phase");
    expect_at(L, M_MODE, 5'b00000, "R9 last low cycle");
    expect_at(L + 1, M_MODE, 5'b00001, "R9 released");
    tick(1); cas_evt = 1'b0;
    tick(L + 2);
    irq_ack = 1'b1; tick(1); irq_ack = 1'b0; tick(1);

    // R9 restart
    cas_evt = 1'b1; tick(1); cas_evt = 1'b0; tick(3);
    cas_evt = 1'b1;
    expect_at(L, M_MODE, 5'b00000, "R9 restart keeps low");
    expect_at(L + 1, M_MODE, 5'b00001, "R9 restart release");
    tick(1); cas_evt = 1'b0;
    tick(L + 2);

    // R10 mark during MODE low, R6 data phase
    cas_evt = 1'b1; tick(1); cas_evt = 1'b0; tick(2);
    mark_evt = 1'b1;
    expect_at(1, M_ALL, 5'b00101, "R10 mark forces MODE high, R6 data");
    tick(1); mark_evt = 1'b0; tick(1);

    // R11 re-initialisation pulse of 5 clocks
    pd_code = 2'b00;
    tick(3);
    expect_at(1, M_EN, 5'b00100, "R11 enables held during pulse");
    tick(2);
    pd_code = 2'b01;
    expect_at(1, M_IRQ, 5'b00000, "R11 irq before reinit");
    expect_at(2, M_ALL, 5'b01011, "R11 reinit to tone");
    tick(3);

    // R12 short glitch
    cas_evt = 1'b1; tick(1); cas_evt = 1'b0; tick(1);
    pd_code = 2'b00;
    tick(3);
    pd_code = 2'b01;
    expect_at(2, 5'b11110, 5'b01100, "R12 glitch ignored");
    expect_at(3, 5'b11110, 5'b01100, "R12 glitch ignored later");
    tick(4);

    // R11 pulse at the maximum length
    pd_code = 2'b00;
    tick(8);
    pd_code = 2'b01;
    expect_at(2, M_ALL, 5'b01011, "R11 max-length pulse");
    tick(3);

    // R13 long low becomes a level, R3 and R4 low-level rows
    cas_evt = 1'b1; tick(1); cas_evt = 1'b0; tick(1);
    pd_code = 2'b00;
    expect_at(8, M_EN, 5'b01100, "R13 level held at 8");
    expect_at(9, M_EN, 5'b00100, "R13 low level adopted, R3");
    tick(10);
    off_hook = 1'b1;
    expect_at(1, M_EN, 5'b01000, "R4 low off-hook tone");
    tick(2);
    off_hook = 1'b0;
    expect_at(1, M_EN, 5'b00100, "R3 low on-hook fsk only");
    tick(2);
    pd_code = 2'b01;
    expect_at(2, 5'b11110, 5'b01000, "R13 no reinit after long low");
    tick(3);

    // R8 event wins over acknowledge
    irq_ack = 1'b1;
    expect_at(1, M_IRQ, 5'b00010, "R8 ack");
    tick(1); irq_ack = 1'b0; tick(1);
    cas_evt = 1'b1; irq_ack = 1'b1;
    expect_at(1, M_IRQ, 5'b00000, "R8 event beats ack");
    tick(1); cas_evt = 1'b0; irq_ack = 1'b0;
    tick(3);

    while (sb.size() != 0) tick(1);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule